// File: doc/BRIEF.md
# Two-LUT Configurable Logic Cell

This block is one logic cell of a programmable fabric. It holds two 4-input lookup tables, here called the F and G tables, each a 16-entry truth table addressed by its own four inputs. A small 3-input combiner table, H, takes the two table outputs and one extra select input, `h1`. Loaded with the Shannon pattern, the combiner returns G when `h1` is high and F when it is low. The cell then realises any function of five variables: the two tables hold the two halves of the function and `h1` carries the fifth variable. Other combiner patterns give AND, OR, XOR and similar merges of the two tables.

Two combinational outputs, `x` and `y`, each take either their own table or the combiner, as two mode bits choose. Each output also feeds a D flip-flop (`xq`, `yq`), which updates on a rising clock edge when `ce` is high. All table contents and mode bits sit in one 42-bit configuration chain. The chain is loaded serially through a valid/ready stream, one bit per accepted beat. The cell never applies back-pressure: `cfg_ready` is always high, and a producer pauses the stream by lowering `cfg_valid`. The logic outputs follow whatever the chain holds at each moment, so they carry meaning only once all 42 bits have been shifted in.

Top module: `lcell_top`

## Requirements
- R1: A configuration bit is accepted on each rising edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is always 1. On an edge with `cfg_valid` low, the chain is left unchanged whatever `cfg_data` carries.
- R2: Each accepted bit enters at the top of the chain and moves everything one place down, so after 42 beats the first bit sent is chain bit 0. The layout is: bits 15..0 are the F table, bits 31..16 the G table, bits 39..32 the combiner table, bit 40 selects the X source and bit 41 selects the Y source.
- R3: The F output is F-table bit number `f_in`, and the G output is G-table bit number `g_in`.
- R4: The combiner output is combiner-table bit number {`h1`, G output, F output}, with `h1` as the most significant index bit.
- R5: `x` equals the combiner output when bit 40 is 1, and the F output otherwise. `y` equals the combiner output when bit 41 is 1, and the G output otherwise. Both are combinational.
- R6: On a rising edge with `ce` high, `xq` takes the value `x` had at that edge and `yq` takes the value of `y`.
- R7: On a rising edge with `ce` low, `xq` and `yq` keep their values.
- R8: An asynchronous active-low reset clears the chain, `xq` and `yq`. After reset, `x` and `y` read 0 for every input.
- R9: With combiner table 0xCA and X selecting the combiner, `x` equals bit {`h1`, `f_in`} of the 32-bit function formed with the G table as the upper half and the F table as the lower half, when `g_in` equals `f_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Configuration bit on `cfg_data` is offered |
| cfg_data | input | 1 | Serial configuration bit |
| cfg_ready | output | 1 | Cell accepts a configuration bit (always 1) |
| f_in | input | LUT_K | Address of the F table |
| g_in | input | LUT_K | Address of the G table |
| h1 | input | 1 | Extra combiner input, the fifth variable |
| ce | input | 1 | Clock enable of the output flip-flops |
| x | output | 1 | Combinational X output |
| y | output | 1 | Combinational Y output |
| xq | output | 1 | Registered X |
| yq | output | 1 | Registered Y |

## Verification
A chain bit that is lost, duplicated or shifted one place shows up at `x` or `y` in the same cycle as soon as the inputs address the affected table entry. A misplaced mode bit swaps which source an output follows. Exhaustive sweeps of all 32 input combinations after each load expose any such offset within one load. A wrong flip-flop state appears at `xq`/`yq` one edge after the capture, and only stays hidden while `ce` keeps the flip-flops holding.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  // default number of address bits of each main lookup table
  localparam int unsigned LUT_K_DEF = 4;
  // the combiner looks at F, G and the extra select input
  localparam int unsigned COMB_K = 3;

  typedef enum logic {
    SRC_LUT  = 1'b0,
    SRC_COMB = 1'b1
  } src_sel_e;
endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
  parameter int unsigned W = 42
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] cfg
);
  // new bit enters at the top; after W beats the first bit rests at index 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg <= '0;
    else if (shift_en) cfg <= {bit_in, cfg[W-1:1]};
  end
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int unsigned K = 4,
  localparam int unsigned DEPTH = 1 << K
) (
  input  logic [DEPTH-1:0] tab,
  input  logic [K-1:0]     sel,
  output logic             o
);
  assign o = tab[sel];
endmodule

// File: rtl/lcell_out_stage.sv
module lcell_out_stage
  import lcell_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ce,
  input  logic     f_o,
  input  logic     g_o,
  input  logic     h_o,
  input  src_sel_e x_src,
  input  src_sel_e y_src,
  output logic     x,
  output logic     y,
  output logic     xq,
  output logic     yq
);
  localparam int unsigned NCH = 2;

  logic     [NCH-1:0] own_v;
  src_sel_e           src [NCH];
  logic     [NCH-1:0] comb_v;
  logic     [NCH-1:0] q_v;

  assign own_v  = {g_o, f_o};
  assign src[0] = x_src;
  assign src[1] = y_src;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign comb_v[i] = (src[i] == SRC_COMB) ? h_o : own_v[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_v[i] <= 1'b0;
      else if (ce) q_v[i] <= comb_v[i];
    end
  end

  assign x  = comb_v[0];
  assign y  = comb_v[1];
  assign xq = q_v[0];
  assign yq = q_v[1];
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
#(
  parameter int unsigned LUT_K = LUT_K_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_data,
  output logic             cfg_ready,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic             h1,
  input  logic             ce,
  output logic             x,
  output logic             y,
  output logic             xq,
  output logic             yq
);
  localparam int unsigned TAB_W  = 1 << LUT_K;
  localparam int unsigned H_W    = 1 << COMB_K;
  localparam int unsigned H_LO   = 2 * TAB_W;
  localparam int unsigned XS_BIT = H_LO + H_W;
  localparam int unsigned YS_BIT = XS_BIT + 1;
  localparam int unsigned CFG_W  = YS_BIT + 1;
  localparam int unsigned NLUT   = 2;

  logic [CFG_W-1:0] cfg_q;
  logic [NLUT-1:0]  lut_o;
  logic [LUT_K-1:0] lut_sel [NLUT];
  logic             h_o;

  // the chain can take a bit every cycle, so it never stalls the producer
  assign cfg_ready = 1'b1;

  lcell_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_valid & cfg_ready),
    .bit_in   (cfg_data),
    .cfg      (cfg_q)
  );

  assign lut_sel[0] = f_in;
  assign lut_sel[1] = g_in;

  // F table occupies the low slice, G the next one
  for (genvar i = 0; i < NLUT; i++) begin : g_lut
    lcell_lut #(.K(LUT_K)) u_lut (
      .tab (cfg_q[i*TAB_W +: TAB_W]),
      .sel (lut_sel[i]),
      .o   (lut_o[i])
    );
  end

  lcell_lut #(.K(COMB_K)) u_comb (
    .tab (cfg_q[H_LO +: H_W]),
    .sel ({h1, lut_o[1], lut_o[0]}),
    .o   (h_o)
  );

  lcell_out_stage u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .f_o   (lut_o[0]),
    .g_o   (lut_o[1]),
    .h_o   (h_o),
    .x_src (src_sel_e'(cfg_q[XS_BIT])),
    .y_src (src_sel_e'(cfg_q[YS_BIT])),
    .x     (x),
    .y     (y),
    .xq    (xq),
    .yq    (yq)
  );
endmodule

// File: rtl/lcell_top_chk.sv
module lcell_top_chk #(
  parameter int unsigned LUT_K = 4,
  localparam int unsigned CFG_W = 2 * (1 << LUT_K) + 8 + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             cfg_data,
  input logic             ce,
  input logic             x,
  input logic             y,
  input logic             xq,
  input logic             yq,
  input logic [CFG_W-1:0] cfg_q
);
  // R1 / R2: accepted bit lands at the top, the rest moves down one place
  p_shift_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_q[CFG_W-1] == $past(cfg_data));
  p_shift_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_q[CFG_W-2:0] == $past(cfg_q[CFG_W-1:1]));
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> $stable(cfg_q));

  // R6: capture of the combinational outputs
  p_xq_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> xq == $past(x));
  p_yq_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> yq == $past(y));

  // R7: hold without enable
  p_xq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(xq));
  p_yq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(yq));
endmodule

bind lcell_top lcell_top_chk #(.LUT_K(LUT_K)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .cfg_data  (cfg_data),
  .ce        (ce),
  .x         (x),
  .y         (y),
  .xq        (xq),
  .yq        (yq),
  .cfg_q     (cfg_q)
);

// File: tb/sim_lcell_top.sv
module sim_lcell_top;
  localparam int CW = 42;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_data = 1'b0;
  logic       cfg_ready;
  logic [3:0] f_in = '0;
  logic [3:0] g_in = '0;
  logic       h1 = 1'b0;
  logic       ce = 1'b0;
  logic       x, y, xq, yq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [CW-1:0] cur_cfg = '0;
  logic exp_xq = 1'b0;
  logic exp_yq = 1'b0;

  always #4 clk = ~clk;

  lcell_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
    .cfg_ready(cfg_ready), .f_in(f_in), .g_in(g_in), .h1(h1), .ce(ce),
    .x(x), .y(y), .xq(xq), .yq(yq)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (f_in=%0d g_in=%0d h1=%b)",
               req, what, act, exp, f_in, g_in, h1);
    end
  endtask

  // model from the requirements: layout of R2, lookups of R3/R4, selection of R5
  function automatic logic [1:0] model_xy(input logic [CW-1:0] c, input logic [3:0] fi,
                                          input logic [3:0] gi, input logic hh);
    logic fo, go, ho;
    fo = c[fi];
    go = c[16 + gi];
    ho = c[32 + {hh, go, fo}];
    return {(c[41] ? ho : go), (c[40] ? ho : fo)};
  endfunction

  task automatic load_cfg(input logic [CW-1:0] v);
    for (int i = 0; i < CW; i++) begin
      while ($urandom % 4 == 0) begin
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_data  = 1'($urandom);
      end
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_data  = v[i];
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    cur_cfg = v;
  endtask

  task automatic check_comb(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      logic [1:0] e;
      f_in = 4'($urandom); g_in = 4'($urandom); h1 = 1'($urandom);
      #1;
      e = model_xy(cur_cfg, f_in, g_in, h1);
      chk(req, "x", x, e[0]);
      chk(req, "y", y, e[1]);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] v;
    logic [31:0]   t;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "xq", xq, 1'b0);
    chk("R8", "yq", yq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cfg_ready", cfg_ready, 1'b1);
    for (int a = 0; a < 32; a += 5) begin
      f_in = 4'(a); g_in = 4'(a + 3); h1 = a[0];
      #1;
      chk("R8", "x", x, 1'b0);
      chk("R8", "y", y, 1'b0);
    end

    // R2/R3: only F entry 0 set, X from F
    v = '0; v[0] = 1'b1;
    load_cfg(v);
    f_in = 4'd0; #1; chk("R2", "x f_in=0", x, 1'b1);
    f_in = 4'd15; #1; chk("R3", "x f_in=15", x, 1'b0);
    // R2/R4: Y from combiner, only combiner entry 4 set -> y follows h1 with zero tables
    v = '0; v[41] = 1'b1; v[36] = 1'b1;
    load_cfg(v);
    f_in = 4'd7; g_in = 4'd9;
    h1 = 1'b0; #1; chk("R4", "y h1=0", y, 1'b0);
    h1 = 1'b1; #1; chk("R4", "y h1=1", y, 1'b1);
    chk("R1", "cfg_ready", cfg_ready, 1'b1);

    // R3/R4/R5: random configurations
    for (int n = 0; n < 16; n++) begin
      v = {10'($urandom), $urandom};
      load_cfg(v);
      check_comb("R5", 24);
    end

    // R1: beats with valid low are ignored even as data toggles
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      cfg_valid = 1'b0;
      cfg_data  = 1'($urandom);
    end
    @(negedge clk);
    check_comb("R1", 24);

    // R9: Shannon expansion of random 5-variable functions, every combination
    for (int n = 0; n < 6; n++) begin
      t = $urandom;
      v = {1'b0, 1'b1, 8'hCA, t};
      load_cfg(v);
      for (int c = 0; c < 32; c++) begin
        f_in = 4'(c); g_in = 4'(c); h1 = c[4];
        #1;
        chk("R9", "x shannon", x, t[c]);
        chk("R9", "y from G", y, t[16 + c[3:0]]);
      end
    end

    // R6/R7: registers with random enable
    v = {10'($urandom), $urandom};
    load_cfg(v);
    for (int n = 0; n < 300; n++) begin
      logic [1:0] e;
      logic nx, ny;
      @(negedge clk);
      f_in = 4'($urandom); g_in = 4'($urandom); h1 = 1'($urandom);
      ce = 1'($urandom);
      #1;
      e = model_xy(cur_cfg, f_in, g_in, h1);
      nx = ce ? e[0] : exp_xq;
      ny = ce ? e[1] : exp_yq;
      @(posedge clk);
      #1;
      chk(ce ? "R6" : "R7", "xq", xq, nx);
      chk(ce ? "R6" : "R7", "yq", yq, ny);
      exp_xq = nx;
      exp_yq = ny;
    end
    @(negedge clk);
    ce = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule